// File: doc/BRIEF.md
# Event-Driven State Configurable Timer

This block is a prescaled 32-bit counter paired with a two-state event machine. Six programmable events each watch a counter match, a level or edge on one pin, or a combination of the two. An event can fire only in the states its mask allows. Each event that fires can do any of the following: set or clear outputs, load a new state, start, stop or halt the counter, reload the counter to zero, capture the count, and raise an interrupt flag.

Software configures the block through a single-cycle write port and reads its state back through a combinational read port. Four pins come in through synchronizers and four outputs leave from registers. Five registers each act as a match value or as a capture target. A typical use is PWM. One match event sets an output and reloads the counter. A second match event clears the output. Pin events steer the state or freeze the count.

Top module: `evt_timer`

## Requirements
- R1: After reset the outputs, count, state, flags, prescale and all event definitions (state mask 0) are zero, and the stop bit is set, so nothing counts or fires. The control register is at address 0, with halt in bit 0, stop in bit 1 and prescale P in bits 15:8. A write to it replaces all three fields.
- R2: While halt and stop are both clear, the count advances by one on every (P+1)th clock, which is a tick. The count is read and written at address 1. A write there loads the count directly and overrides any change an event would make.
- R3: The value registers are at addresses 8 up to 12, and address 3 holds a mode bit for each of them (1 = capture). A register in match mode matches on a clock that is a tick while the count equals its value.
- R4: Each pin passes through two flops. The condition field (definition bits 7:6) selects 0 low, 1 high, 2 rising or 3 falling. It applies to the pin chosen by bits 4:3, or to that output pin when bit 5 is set. An edge is a difference between two consecutive synchronized samples, or between two consecutive output values.
- R5: Event e's definition is at address 16+e. Bits 2:0 choose the match register, and the values 5 to 7 never match. Bits 9:8 combine the terms: 0 match OR pin, 1 match only, 2 pin only, 3 match AND pin.
- R6: Definition bits 11:10 are the state mask. An event fires only when bit 10+state of its definition is set.
- R7: Event e's actions are at address 24+e, with bits 3:0 setting outputs and bits 7:4 clearing them. When both hit the same output, the 2-bit field for that output at address 4 (bits 2i+1:2i) selects 0 hold, 1 set, 2 clear or 3 toggle. Outputs change on the next clock edge. A write to address 7 loads the outputs and overrides events.
- R8: Action bit 8 requests a state load, and bit 9 gives the new state. When several events load in the same cycle, the highest-numbered one wins. Address 2 reads and writes the state, and a write overrides events.
- R9: Action bit 10 clears stop, and bit 11 sets stop, which wins over bit 10. Bit 12 sets halt, and halt stays set until a control write clears it.
- R10: Action bits 18:14 are a capture mask. A selected register in capture mode loads the count as it stood before the edge. A selected register in match mode is left unchanged.
- R11: Each firing event sets its sticky flag (address 6). Writing ones to address 6 clears those flags, but a flag set in the same cycle stays set. The irq output is the OR of the flags ANDed with the enables at address 5.
- R12: Action bit 13 reloads the count to zero at a tick in place of the increment. When no tick falls in that cycle, the reload waits for the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| pin_in | input | 4 | Asynchronous input pins |
| pin_out | output | 4 | Registered outputs |
| irq | output | 1 | Interrupt request |

## Verification
The event machine runs in several configurations while the input pins change pseudo-randomly every clock. The first is a two-match PWM with a limit, which separates match timing from the prescaler. Next come rising and falling pin events, which expose mistakes in synchronizer depth and edge polarity. AND and OR combinations of match and pin terms, together with output-edge conditions, show whether the combine field and the output history are decoded correctly. A forced set/clear collision is repeated under each of the four resolution codes. Pin-driven stop, start, halt, off-tick limit and capture phases show whether counter control and capture use the count from before the edge and whether a pending reload waits for a tick.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int NI = 4,
  parameter int NO = 4,
  parameter int NM = 5,
  parameter int NE = 6,
  parameter int CW = 32,
  parameter int PW = 8,
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [NI-1:0] pin_in,
  output logic [NO-1:0] pin_out,
  output logic          irq
);
  localparam int A_CTL = 0, A_CNT = 1, A_ST = 2, A_MODE = 3, A_RES = 4;
  localparam int A_IEN = 5, A_FLG = 6, A_OUT = 7, A_MR = 8, A_CFG = 16, A_ACT = 24;
  localparam int CFG_W = 12;
  localparam int K_LD = 2*NO, K_NST = K_LD+1, K_GO = K_LD+2, K_STOP = K_LD+3;
  localparam int K_HALT = K_LD+4, K_LIM = K_LD+5, K_CAP = K_LD+6, ACT_W = K_CAP+NM;

  logic halt_q, stop_q, st_q, lim_pend_q;
  logic [PW-1:0] pre_q, pc_q;
  logic [CW-1:0] cnt_q;
  logic [NM-1:0] capmode_q;
  logic [2*NO-1:0] res_q;
  logic [NE-1:0] ien_q, flg_q, fire;
  logic [NO-1:0] out_q, outd_q, out_nx;
  logic [NI-1:0] s1_q, s2_q, s3_q;
  logic [CW-1:0] mr_q [NM];
  logic [CFG_W-1:0] cfg_q [NE];
  logic [ACT_W-1:0] act_q [NE];

  function automatic logic wsel(input int a);
    return wr_en && (wr_addr == AW'(a));
  endfunction

  wire wr_cnt = wsel(A_CNT);
  wire wr_st  = wsel(A_ST);
  wire wr_flg = wsel(A_FLG);
  wire wr_out = wsel(A_OUT);
  wire run    = !halt_q && !stop_q;
  wire tick   = run && (pc_q == pre_q);

  logic [7:0] mhit;
  always_comb begin
    mhit = '0;
    for (int j = 0; j < NM; j++) mhit[j] = tick && !capmode_q[j] && (cnt_q == mr_q[j]);
  end

  for (genvar e = 0; e < NE; e++) begin : g_ev
    wire [1:0] psel = cfg_q[e][4:3];
    wire cur = cfg_q[e][5] ? out_q[psel]  : s2_q[psel];
    wire prv = cfg_q[e][5] ? outd_q[psel] : s3_q[psel];
    wire m   = mhit[cfg_q[e][2:0]];
    logic io, c;
    always_comb begin
      case (cfg_q[e][7:6])
        2'd0: io = !cur;
        2'd1: io = cur;
        2'd2: io = cur && !prv;
        default: io = !cur && prv;
      endcase
      case (cfg_q[e][9:8])
        2'd0: c = m || io;
        2'd1: c = m;
        2'd2: c = io;
        default: c = m && io;
      endcase
    end
    assign fire[e] = c && (st_q ? cfg_q[e][11] : cfg_q[e][10]);
  end

  logic [NO-1:0] set_all, clr_all;
  logic [NM-1:0] cap_all;
  logic ev_go, ev_stop, ev_halt, ev_lim, ev_ld, ev_nst;
  always_comb begin
    set_all = '0; clr_all = '0; cap_all = '0;
    ev_go = 1'b0; ev_stop = 1'b0; ev_halt = 1'b0; ev_lim = 1'b0; ev_ld = 1'b0; ev_nst = 1'b0;
    for (int e = 0; e < NE; e++) begin
      if (fire[e]) begin
        set_all |= act_q[e][NO-1:0];
        clr_all |= act_q[e][2*NO-1:NO];
        cap_all |= act_q[e][K_CAP +: NM];
        ev_go   |= act_q[e][K_GO];
        ev_stop |= act_q[e][K_STOP];
        ev_halt |= act_q[e][K_HALT];
        ev_lim  |= act_q[e][K_LIM];
        if (act_q[e][K_LD]) begin
          ev_ld  = 1'b1;
          ev_nst = act_q[e][K_NST];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NO; i++) begin
      case ({set_all[i], clr_all[i]})
        2'b10: out_nx[i] = 1'b1;
        2'b01: out_nx[i] = 1'b0;
        2'b11:
          case (res_q[2*i +: 2])
            2'd1: out_nx[i] = 1'b1;
            2'd2: out_nx[i] = 1'b0;
            2'd3: out_nx[i] = !out_q[i];
            default: out_nx[i] = out_q[i];
          endcase
        default: out_nx[i] = out_q[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0; stop_q <= 1'b1; st_q <= 1'b0; lim_pend_q <= 1'b0;
      pre_q <= '0; pc_q <= '0; cnt_q <= '0; capmode_q <= '0; res_q <= '0;
      ien_q <= '0; flg_q <= '0; out_q <= '0; outd_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
      for (int j = 0; j < NM; j++) mr_q[j] <= '0;
      for (int e = 0; e < NE; e++) begin
        cfg_q[e] <= '0;
        act_q[e] <= '0;
      end
    end else begin
      s1_q <= pin_in; s2_q <= s1_q; s3_q <= s2_q;
      outd_q <= out_q;
      if (wsel(A_CTL)) begin
        halt_q <= wr_data[0];
        stop_q <= wr_data[1];
        pre_q  <= wr_data[8 +: PW];
      end else begin
        halt_q <= halt_q || ev_halt;
        stop_q <= ev_stop || (stop_q && !ev_go);
      end
      pc_q <= (!run || tick) ? '0 : pc_q + PW'(1);
      if (wr_cnt) cnt_q <= wr_data[CW-1:0];
      else if (tick) cnt_q <= (ev_lim || lim_pend_q) ? '0 : cnt_q + CW'(1);
      lim_pend_q <= !(tick || wr_cnt) && (lim_pend_q || ev_lim);
      if (wr_st) st_q <= wr_data[0];
      else if (ev_ld) st_q <= ev_nst;
      if (wsel(A_MODE)) capmode_q <= wr_data[NM-1:0];
      if (wsel(A_RES))  res_q     <= wr_data[2*NO-1:0];
      if (wsel(A_IEN))  ien_q     <= wr_data[NE-1:0];
      flg_q <= (wr_flg ? (flg_q & ~wr_data[NE-1:0]) : flg_q) | fire;
      out_q <= wr_out ? wr_data[NO-1:0] : out_nx;
      for (int j = 0; j < NM; j++) begin
        if (wsel(A_MR + j)) mr_q[j] <= wr_data[CW-1:0];
        else if (capmode_q[j] && cap_all[j]) mr_q[j] <= cnt_q;
      end
      for (int e = 0; e < NE; e++) begin
        if (wsel(A_CFG + e)) cfg_q[e] <= wr_data[CFG_W-1:0];
        if (wsel(A_ACT + e)) act_q[e] <= wr_data[ACT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CNT)) rd_data = DW'(cnt_q);
    if (rd_addr == AW'(A_ST))  rd_data = DW'(st_q);
    if (rd_addr == AW'(A_FLG)) rd_data = DW'(flg_q);
    if (rd_addr == AW'(A_OUT)) rd_data = DW'(out_q);
    for (int j = 0; j < NM; j++)
      if (rd_addr == AW'(A_MR + j)) rd_data = DW'(mr_q[j]);
  end

  assign pin_out = out_q;
  assign irq     = |(flg_q & ien_q);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ev_lim && !lim_pend_q && !wr_cnt) |=> cnt_q == $past(cnt_q) + CW'(1));
  p_limit_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (ev_lim || lim_pend_q) && !wr_cnt) |=> cnt_q == '0);
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_cnt) |=> cnt_q == $past(cnt_q));
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flg |=> (($past(flg_q) & ~flg_q) == '0));
  p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_ld && !wr_st) |=> $stable(st_q));
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all == '0 && clr_all == '0 && !wr_out) |=> $stable(out_q));
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_out;
  logic irq;

  evt_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, ridx = 0, cycles = 0;
  bit checking = 1'b0;
  string phase = "R1";
  logic [15:0] lf = 16'hACE1;

  // reference model state
  logic [31:0] m_cnt, m_mr[5];
  logic [7:0] m_pre, m_pc, m_res;
  bit m_halt, m_stop, m_st, m_limp;
  logic [4:0] m_capm;
  logic [5:0] m_ien, m_flg;
  logic [3:0] m_out, m_outd, m_s1, m_s2, m_s3;
  logic [11:0] m_cfg[6];
  logic [18:0] m_act[6];

  task automatic model_reset();
    m_cnt = 0; m_pre = 0; m_pc = 0; m_res = 0; m_halt = 0; m_stop = 1; m_st = 0; m_limp = 0;
    m_capm = 0; m_ien = 0; m_flg = 0; m_out = 0; m_outd = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    for (int j = 0; j < 5; j++) m_mr[j] = 0;
    for (int e = 0; e < 6; e++) begin m_cfg[e] = 0; m_act[e] = 0; end
  endtask

  function automatic bit wa(int a);
    return wr_en && (wr_addr == a[5:0]);
  endfunction

  task automatic model_step();
    bit run, tick, hit, cur, prv, io, c, go, stp, hlt, lim, ld, nst;
    logic [5:0] fired;
    logic [3:0] setm, clrm, onext;
    logic [4:0] capm;
    int ms, p;
    run = !m_halt && !m_stop;
    tick = run && (m_pc == m_pre);
    fired = 0;
    for (int e = 0; e < 6; e++) begin
      ms = m_cfg[e][2:0];
      p = m_cfg[e][4:3];
      hit = 0;
      if (ms < 5) hit = tick && !m_capm[ms] && (m_cnt == m_mr[ms]);
      cur = m_cfg[e][5] ? m_out[p] : m_s2[p];
      prv = m_cfg[e][5] ? m_outd[p] : m_s3[p];
      case (m_cfg[e][7:6])
        0: io = !cur;
        1: io = cur;
        2: io = cur && !prv;
        default: io = !cur && prv;
      endcase
      case (m_cfg[e][9:8])
        0: c = hit || io;
        1: c = hit;
        2: c = io;
        default: c = hit && io;
      endcase
      fired[e] = c && m_cfg[e][10 + m_st];
    end
    setm = 0; clrm = 0; capm = 0; go = 0; stp = 0; hlt = 0; lim = 0; ld = 0; nst = 0;
    for (int e = 0; e < 6; e++) if (fired[e]) begin
      setm |= m_act[e][3:0]; clrm |= m_act[e][7:4]; capm |= m_act[e][18:14];
      go |= m_act[e][10]; stp |= m_act[e][11]; hlt |= m_act[e][12]; lim |= m_act[e][13];
    end
    for (int e = 5; e >= 0; e--) if (fired[e] && m_act[e][8]) begin
      ld = 1; nst = m_act[e][9]; break;
    end
    for (int i = 0; i < 4; i++) begin
      onext[i] = m_out[i];
      if (setm[i] && !clrm[i]) onext[i] = 1;
      else if (clrm[i] && !setm[i]) onext[i] = 0;
      else if (setm[i] && clrm[i]) begin
        case (m_res[2*i +: 2])
          1: onext[i] = 1;
          2: onext[i] = 0;
          3: onext[i] = !m_out[i];
          default: onext[i] = m_out[i];
        endcase
      end
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    for (int j = 0; j < 5; j++) begin
      if (wa(8 + j)) m_mr[j] = wr_data;
      else if (m_capm[j] && capm[j]) m_mr[j] = m_cnt;
    end
    m_outd = m_out;
    m_out = wa(7) ? wr_data[3:0] : onext;
    m_flg = (wa(6) ? (m_flg & ~wr_data[5:0]) : m_flg) | fired;
    if (wa(2)) m_st = wr_data[0]; else if (ld) m_st = nst;
    if (wa(1)) m_cnt = wr_data;
    else if (tick) m_cnt = (lim || m_limp) ? 0 : m_cnt + 1;
    m_limp = !(tick || wa(1)) && (m_limp || lim);
    m_pc = (!run || tick) ? 8'd0 : m_pc + 8'd1;
    if (wa(0)) begin m_halt = wr_data[0]; m_stop = wr_data[1]; m_pre = wr_data[15:8]; end
    else begin m_halt = m_halt || hlt; if (stp) m_stop = 1; else if (go) m_stop = 0; end
    if (wa(3)) m_capm = wr_data[4:0];
    if (wa(4)) m_res = wr_data[7:0];
    if (wa(5)) m_ien = wr_data[5:0];
    for (int e = 0; e < 6; e++) begin
      if (wa(16 + e)) m_cfg[e] = wr_data[11:0];
      if (wa(24 + e)) m_act[e] = wr_data[18:0];
    end
  endtask

  function automatic logic [31:0] m_rd(logic [5:0] a);
    if (a == 1) return m_cnt;
    if (a == 2) return {31'd0, m_st};
    if (a == 6) return {26'd0, m_flg};
    if (a == 7) return {28'd0, m_out};
    if (a >= 8 && a < 13) return m_mr[a - 8];
    return 0;
  endfunction

  function automatic logic [5:0] rlist(int i);
    case (i)
      0: return 1;  1: return 2;  2: return 6;  3: return 7;  4: return 8;
      5: return 9;  6: return 10; 7: return 11; 8: return 12; default: return 3;
    endcase
  endfunction

  initial model_reset();
  always @(posedge clk or negedge rst_n)
    if (!rst_n) model_reset(); else model_step();

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && checking) begin
    chk(phase, "pin_out", {28'd0, pin_out}, {28'd0, m_out});
    chk(phase, "irq", {31'd0, irq}, {31'd0, |(m_flg & m_ien)});
    chk(phase, $sformatf("rd_data@%0d", rd_addr), rd_data, m_rd(rd_addr));
  end

  always @(posedge clk) begin
    #1;
    ridx = (ridx + 1) % 10;
    rd_addr = rlist(ridx);
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic wreg(int a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a[5:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic cyc(int n, bit rnd);
    repeat (n) begin
      @(posedge clk); #1;
      if (rnd) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        pin_in = lf[3:0];
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset values seen at the ports
    chk("R1", "pin_out reset", {28'd0, pin_out}, 32'd0);
    chk("R1", "irq reset", {31'd0, irq}, 32'd0);
    checking = 1;
    cyc(6, 0);

    phase = "R2";
    wreg(1, 32'd100);
    wreg(0, 32'h0000_0200);
    cyc(30, 0);

    phase = "R3";
    wreg(8, 32'd7);
    wreg(9, 32'd3);
    wreg(16, 32'h500); wreg(24, 32'h2001);
    wreg(1, 32'd0);
    wreg(17, 32'h501); wreg(25, 32'h10);
    cyc(80, 0);

    phase = "R4";
    wreg(18, 32'hE88); wreg(26, 32'h2);
    wreg(19, 32'hEC8); wreg(27, 32'h20);
    cyc(100, 1);

    phase = "R5";
    wreg(20, 32'hF51); wreg(28, 32'h4);
    wreg(21, 32'hCE0); wreg(29, 32'h8);
    cyc(120, 1);

    phase = "R7";
    wreg(0, 32'h0000_0000);
    wreg(20, 32'hF51); wreg(28, 32'h8);
    wreg(21, 32'hD01); wreg(29, 32'h80);
    for (int r = 0; r < 4; r++) begin
      wreg(4, r << 6);
      cyc(60, 1);
    end
    wreg(7, 32'h5);
    cyc(5, 0);

    phase = "R8";
    wreg(26, 32'h302); wreg(27, 32'h120);
    wreg(25, 32'h110); wreg(29, 32'h380);
    cyc(150, 1);

    phase = "R6";
    wreg(2, 32'd1);
    cyc(20, 0);
    wreg(2, 32'd0);
    cyc(40, 0);

    phase = "R9";
    wreg(18, 32'hE80); wreg(26, 32'h800);
    wreg(19, 32'hEC0); wreg(27, 32'h400);
    cyc(100, 1);
    wreg(27, 32'h1000);
    cyc(60, 1);
    wreg(27, 32'h0);
    wreg(0, 32'h0000_0200);
    cyc(40, 0);

    phase = "R12";
    wreg(0, 32'h0000_0400);
    wreg(26, 32'h2000);
    cyc(100, 1);

    phase = "R10";
    wreg(3, 32'h08);
    wreg(27, 32'h24000);
    cyc(100, 1);

    phase = "R11";
    wreg(5, 32'h3F);
    cyc(40, 1);
    wreg(6, 32'h0F);
    cyc(20, 1);
    wreg(5, 32'h01);
    wreg(6, 32'h3F);
    cyc(40, 1);

    @(negedge clk);
    finish_run();
  end
endmodule